// File: doc/BRIEF.md
# Paired Transmit/Receive Word Buffer

This block holds the words that pass between a host register interface and a serial byte engine. It has two independent first-in first-out lanes of 9-bit words. The host writes into the transmit lane, and the engine pops from it. The engine pushes into the receive lane, and the host pops from it. In each word, the byte sits in bits 8:1 and the acknowledge bit sits in bit 0. The buffer moves all nine bits unchanged and gives no meaning to either field.

Each lane reports its occupancy through a fill field, a full flag and a half flag. The fill field is only as wide as the pointer, so a lane holding its full depth shows zero in the fill field. Software must therefore read the full flag to tell a full lane from an empty one. Each lane has its own enable. With the enable low, the lane keeps at most one word. A soft-reset input empties both lanes. If that soft reset arrives while the receive lane still holds words, the block raises a sticky busy error to show that the receive data was not drained first.

Top module: `sfifo_pair`

## Requirements
- R1: With its enable high, a lane accepts up to DEPTH (8) words and returns them in the order they were pushed. The count never exceeds DEPTH.
- R2: The 3-bit fill field equals the word count modulo 8. When a lane holds exactly 8 words, the fill field reads 0 and the lane's full flag is 1.
- R3: A lane's half flag is 1 exactly when it holds 4 or more words.
- R4: A push into a full lane is dropped. The count and the stored words stay unchanged.
- R5: A pop from an empty lane leaves its read-data output at the last popped value and the count at 0.
- R6: With its enable low, a lane holds at most one word. Its full flag is set as soon as one word is stored, and a second push is dropped.
- R7: Soft reset empties both lanes in one cycle. Counts, fill fields, flags and read-data outputs all become 0, and soft reset takes priority over a push or pop in the same cycle.
- R8: A soft reset applied while the receive lane is non-empty sets busy_err. A soft reset applied while the receive lane is empty clears it.
- R9: The word layout is byte in bits 8:1 and acknowledge in bit 0. Both fields come out of the lane exactly as they went in.
- R10: A push and a pop in the same cycle on a lane that is neither empty nor full are both accepted. The count stays the same. A push into a lane that is full before the pop is still dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both lanes |
| tx_fifo_en | input | 1 | Transmit lane enable (0 = single-word buffer) |
| rx_fifo_en | input | 1 | Receive lane enable (0 = single-word buffer) |
| host_wr | input | 1 | Host push into the transmit lane |
| host_wdata | input | 9 | Word pushed by the host |
| host_rd | input | 1 | Host pop from the receive lane |
| host_rdata | output | 9 | Last word popped from the receive lane |
| eng_tx_pop | input | 1 | Engine pop from the transmit lane |
| eng_tx_data | output | 9 | Last word popped from the transmit lane |
| eng_rx_push | input | 1 | Engine push into the receive lane |
| eng_rx_data | input | 9 | Word pushed by the engine |
| tx_fill | output | 3 | Transmit word count modulo 8 |
| tx_full | output | 1 | Transmit lane at capacity |
| tx_half | output | 1 | Transmit lane holds 4 or more words |
| rx_fill | output | 3 | Receive word count modulo 8 |
| rx_full | output | 1 | Receive lane at capacity |
| rx_half | output | 1 | Receive lane holds 4 or more words |
| busy_err | output | 1 | Sticky: soft reset was seen with receive data pending |

## Verification
The bench builds the block with its default parameters: 9-bit words, a depth of 8 and a 3-bit fill field. With these values, a full sweep from empty to full and back is short, and it passes through the point where the fill field wraps to zero. The sweep covers every occupancy from 0 to 8 on both lanes, with each enable both high and low. The single-word capacity, the dropped overflow push and the pop from empty are all reached at these sizes. Separate cases cover a push and pop in the same cycle, and a soft reset with and without receive data pending.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int WORD_W  = 9;
    localparam int DEPTH   = 8;
    localparam int FILL_W  = $clog2(DEPTH);
    localparam int ACK_BIT = 0;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t mk_word(input logic [7:0] byte_v, input logic ack_v);
        return {byte_v, ack_v};
    endfunction
endpackage

// File: rtl/sfifo_level.sv
module sfifo_level #(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4,
    parameter int FILL_W = 3
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cap,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              half
);
    localparam int HALF_MARK = DEPTH / 2;

    always_comb begin
        fill = cnt[FILL_W-1:0];
        full = (cnt >= cap);
        half = (cnt >= CNT_W'(HALF_MARK));
    end
endmodule

// File: rtl/sfifo_lane.sv
module sfifo_lane #(
    parameter int W      = 9,
    parameter int DEPTH  = 8,
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              push,
    input  logic [W-1:0]      wdata,
    input  logic              pop,
    output logic [W-1:0]      rdata,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              half
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
        logic [W-1:0]            rdata;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic [CNT_W-1:0] cap;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap = en ? CNT_W'(DEPTH) : CNT_W'(1);

    sfifo_level #(
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .FILL_W (FILL_W)
    ) u_level (
        .cnt  (st_q.cnt),
        .cap  (cap),
        .fill (fill),
        .full (full),
        .half (half)
    );

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d.wr    = '0;
            st_d.rd    = '0;
            st_d.cnt   = '0;
            st_d.rdata = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr           = ptr_nxt(st_q.wr);
            end
            if (pop_ok) begin
                st_d.rdata = st_q.mem[st_q.rd];
                st_d.rd    = ptr_nxt(st_q.rd);
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R2
    fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && push && !pop && st_q.cnt == CNT_W'(DEPTH - 1))
        |=> (full && fill == '0));

    // R4
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && push && !pop && full) |=> ($stable(st_q.cnt) && $stable(st_q.wr)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pop && !push && st_q.cnt == '0) |=> ($stable(rdata) && $stable(st_q.rd)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill == '0 && !full && !half && rdata == '0));
endmodule

// File: rtl/sfifo_busy_guard.sv
module sfifo_busy_guard #(
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              rx_full,
    output logic              busy_err
);
    typedef struct packed {
        logic busy;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic      occupied;

    always_comb begin
        occupied = (rx_fill != '0) || rx_full;
        st_d     = st_q;
        if (clr) st_d.busy = occupied;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_err = st_q.busy;

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && occupied) |=> busy_err);

    // R8
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !occupied) |=> !busy_err);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(busy_err));
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
    import sfifo_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = sfifo_pkg::DEPTH,
    parameter int FW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          tx_fifo_en,
    input  logic          rx_fifo_en,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          eng_tx_pop,
    output logic [W-1:0]  eng_tx_data,
    input  logic          eng_rx_push,
    input  logic [W-1:0]  eng_rx_data,
    output logic [FW-1:0] tx_fill,
    output logic          tx_full,
    output logic          tx_half,
    output logic [FW-1:0] rx_fill,
    output logic          rx_full,
    output logic          rx_half,
    output logic          busy_err
);
    sfifo_lane #(.W(W), .DEPTH(DEPTH), .FILL_W(FW)) u_tx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .en    (tx_fifo_en),
        .push  (host_wr),
        .wdata (host_wdata),
        .pop   (eng_tx_pop),
        .rdata (eng_tx_data),
        .fill  (tx_fill),
        .full  (tx_full),
        .half  (tx_half)
    );

    sfifo_lane #(.W(W), .DEPTH(DEPTH), .FILL_W(FW)) u_rx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .en    (rx_fifo_en),
        .push  (eng_rx_push),
        .wdata (eng_rx_data),
        .pop   (host_rd),
        .rdata (host_rdata),
        .fill  (rx_fill),
        .full  (rx_full),
        .half  (rx_half)
    );

    sfifo_busy_guard #(.FILL_W(FW)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .rx_fill  (rx_fill),
        .rx_full  (rx_full),
        .busy_err (busy_err)
    );

    // R7
    both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_fill == '0 && rx_fill == '0 && !tx_full && !rx_full));
endmodule

// File: tb/sfifo_pair_bench.sv
module sfifo_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       tx_fifo_en = 1'b1;
    logic       rx_fifo_en = 1'b1;
    logic       host_wr = 1'b0;
    logic [8:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [8:0] host_rdata;
    logic       eng_tx_pop = 1'b0;
    logic [8:0] eng_tx_data;
    logic       eng_rx_push = 1'b0;
    logic [8:0] eng_rx_data = '0;
    logic [2:0] tx_fill, rx_fill;
    logic       tx_full, tx_half, rx_full, rx_half, busy_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sfifo_pair u_sfifo_pair (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .tx_fill(tx_fill), .tx_full(tx_full), .tx_half(tx_half),
        .rx_fill(rx_fill), .rx_full(rx_full), .rx_half(rx_half),
        .busy_err(busy_err)
    );

    function automatic logic [8:0] wd(input int id);
        logic [7:0] b;
        b = 8'((id * 37 + 11) & 255);
        return {b, 1'(id & 1)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; soft_rst = 0;
    endtask

    task automatic chk_lvl(input bit is_tx, input int n, input int cap, input string tag);
        int f, fu, h;
        f  = is_tx ? int'(tx_fill) : int'(rx_fill);
        fu = is_tx ? int'(tx_full) : int'(rx_full);
        h  = is_tx ? int'(tx_half) : int'(rx_half);
        chk({tag, " fill"}, f, n % 8);
        chk({tag, " full"}, fu, (n >= cap) ? 1 : 0);
        chk({tag, " half (R3)"}, h, (n >= 4) ? 1 : 0);
    endtask

    task automatic do_push(input bit is_tx, input logic [8:0] w);
        if (is_tx) begin host_wr = 1; host_wdata = w; end
        else begin eng_rx_push = 1; eng_rx_data = w; end
    endtask

    task automatic do_pop(input bit is_tx);
        if (is_tx) eng_tx_pop = 1;
        else host_rd = 1;
    endtask

    function automatic logic [8:0] out_of(input bit is_tx);
        return is_tx ? eng_tx_data : host_rdata;
    endfunction

    task automatic sweep(input bit is_tx, input bit en, input int base);
        int cap, n;
        logic [8:0] got;
        cap = en ? 8 : 1;
        n = 0;
        tx_fifo_en = en; rx_fifo_en = en;
        for (int i = 0; i <= cap; i++) begin
            do_push(is_tx, wd(base + i));
            cyc();
            if (i < cap) n++;
            if (i == cap) chk_lvl(is_tx, n, cap, en ? "R4 overflow" : "R6 overflow");
            else chk_lvl(is_tx, n, cap, en ? "R2 fill" : "R6 fill");
        end
        for (int i = 0; i < cap; i++) begin
            do_pop(is_tx);
            cyc();
            n--;
            got = out_of(is_tx);
            chk("R1 order", int'(got), int'(wd(base + i)));
            chk("R9 byte", int'(got[8:1]), int'(wd(base + i) >> 1));
            chk("R9 ack", int'(got[0]), (base + i) & 1);
            chk_lvl(is_tx, n, cap, "R1 drain");
        end
        do_pop(is_tx);
        cyc();
        chk("R5 empty pop data", int'(out_of(is_tx)), int'(wd(base + cap - 1)));
        chk_lvl(is_tx, 0, cap, "R5 empty pop");
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        // R7 reset state
        chk_lvl(1, 0, 8, "R7 reset tx");
        chk_lvl(0, 0, 8, "R7 reset rx");
        chk("R8 reset busy", int'(busy_err), 0);

        sweep(1, 1, 0);
        sweep(0, 1, 20);
        sweep(1, 0, 40);
        sweep(0, 0, 50);

        // R10 simultaneous push and pop
        tx_fifo_en = 1; rx_fifo_en = 1;
        for (int i = 0; i < 3; i++) begin do_push(1, wd(100 + i)); cyc(); end
        do_push(1, wd(103)); do_pop(1); cyc();
        chk("R10 data", int'(eng_tx_data), int'(wd(100)));
        chk("R10 fill", int'(tx_fill), 3);
        for (int i = 1; i < 4; i++) begin
            do_pop(1); cyc();
            chk("R10 order", int'(eng_tx_data), int'(wd(100 + i)));
        end
        chk("R10 empty", int'(tx_fill), 0);
        // R10 full then push+pop: push dropped
        for (int i = 0; i < 8; i++) begin do_push(0, wd(110 + i)); cyc(); end
        do_push(0, wd(200)); do_pop(0); cyc();
        chk("R10 full push dropped fill", int'(rx_fill), 7);
        chk("R10 full push dropped full", int'(rx_full), 0);
        for (int i = 1; i < 8; i++) begin do_pop(0); cyc(); end
        chk("R10 last kept word", int'(host_rdata), int'(wd(117)));

        // R7/R8 soft reset with receive data pending
        do_push(0, wd(300)); cyc();
        do_push(0, wd(301)); cyc();
        do_push(1, wd(302)); cyc();
        soft_rst = 1; do_push(1, wd(303)); do_pop(0); cyc();
        chk_lvl(1, 0, 8, "R7 clear tx");
        chk_lvl(0, 0, 8, "R7 clear rx");
        chk("R7 rdata cleared", int'(host_rdata), 0);
        chk("R8 busy set", int'(busy_err), 1);
        cyc();
        chk("R8 busy sticky", int'(busy_err), 1);
        soft_rst = 1; cyc();
        chk("R8 busy cleared", int'(busy_err), 0);

        // R8 soft reset with receive lane full (fill reads 0)
        for (int i = 0; i < 8; i++) begin do_push(0, wd(400 + i)); do_push(1, wd(500 + i)); cyc(); end
        chk_lvl(0, 8, 8, "R2 rx full");
        soft_rst = 1; cyc();
        chk("R8 busy at full", int'(busy_err), 1);
        chk_lvl(1, 0, 8, "R7 clear full tx");
        chk_lvl(0, 0, 8, "R7 clear full rx");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule